// File: doc/BRIEF.md
# Byte Serial Shift Port

This block moves single bytes over a synchronous serial link that has two independent directions. The receive path and the transmit path each generate their own shift clock on a dedicated pin. Each path runs one byte per command. The transmit command takes a byte made of two nibbles and clocks it out. The receive command first hands back, in the next cycle, whatever byte the input buffer already held. It then clocks in eight fresh bits. Firmware therefore reads each byte one command late.

Each path has a busy flag, visible in a small status word, and a one-cycle completion pulse. A rate select picks a shift clock of the system clock divided by 2 or divided by 256. When serial mode is off, a mode select gives the same four pins to a 4-bit parallel output latch.

Top module: `serial_byte_port`

## Requirements
- R1: With `ser_mode`=0, `pins_o` equals the last value written through `par_wr`/`par_wdata`, and `pins_oe` is 4'b1111.
- R2: With `ser_mode`=1, pin 0 is transmit data, pin 1 the transmit clock, pin 2 the receive data input and pin 3 the receive clock. `pins_oe` is 4'b1011.
- R3: With `rate_sel`=0 each shift-clock half period lasts 1 system cycle, and the busy flag stays high for 16 cycles. With `rate_sel`=1 a half period lasts 128 cycles, and the busy flag stays high for 2048 cycles.
- R4: A `tx_cmd` sends the byte {`tx_hi`,`tx_lo`} least-significant bit first. It uses 8 clocks on pin 1, and the data bit changes only on a falling clock edge. Both clock pins idle high.
- R5: After the 8th transmit rising edge, status bit 3 (transmit busy) clears and `tx_evt` pulses for exactly one cycle.
- R6: One cycle after `rx_cmd`, `rx_lo`/`rx_hi` show the input buffer as it was before the command. The path then makes 8 clocks on pin 3 and samples `sdin` on each rising edge, least-significant bit first.
- R7: After the 8th receive rising edge, status bit 1 (receive busy) clears and `rx_evt` pulses for exactly one cycle. Status bits 0 and 2 read 0.
- R8: `stat_clr` clears both busy bits at once, and any transfer in progress still runs to completion with its event.
- R9: A command on a path that is still busy restarts that path. The earlier byte is lost, and only one completion event follows.
- R10: After reset the status word is 0, both clock pins are high, the transmit data pin is high, and the returned receive byte and the parallel latch are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_mode | input | 1 | 1 = serial pin roles, 0 = parallel latch on pins |
| rate_sel | input | 1 | 0 = clk/2 shift clock, 1 = clk/256 |
| par_wr | input | 1 | Write strobe for the parallel latch |
| par_wdata | input | 4 | Parallel latch data |
| tx_cmd | input | 1 | Start a transmit byte |
| tx_lo | input | 4 | Transmit byte bits 3:0 |
| tx_hi | input | 4 | Transmit byte bits 7:4 |
| rx_cmd | input | 1 | Return buffer and start a receive byte |
| stat_clr | input | 1 | Clear both busy flags |
| sdin | input | 1 | Serial data input pin |
| rx_lo | output | 4 | Returned byte bits 3:0 |
| rx_hi | output | 4 | Returned byte bits 7:4 |
| stat | output | 4 | Bit 1 receive busy, bit 3 transmit busy |
| tx_evt | output | 1 | Transmit done pulse |
| rx_evt | output | 1 | Receive done pulse |
| pins_o | output | 4 | Pin output values |
| pins_oe | output | 4 | Pin output enables |

## Verification
The hardest case to reach is a second command that lands in the middle of a byte. The transmit clock may be low at that moment, so the restart forces a rising edge that carries no data. The stimulus issues the second transmit a few cycles after the first. The bench resynchronises its edge tracker on the cycle after the command and then compares the full frame against the second byte. Clearing status mid-transfer is done the same way, with a pulse in the middle of a byte followed by a check that the frame and its event still complete. The one-late receive return is exposed by chaining three receives with different input patterns.

// File: rtl/sbp_pkg.sv
package sbp_pkg;
   localparam int unsigned BYTE_W  = 8;
   localparam int unsigned NIB_W   = 4;
   localparam int unsigned NPINS   = 4;
   // pin roles in serial mode
   localparam int unsigned PIN_TXD = 0;
   localparam int unsigned PIN_TXC = 1;
   localparam int unsigned PIN_RXD = 2;
   localparam int unsigned PIN_RXC = 3;
   localparam logic [NPINS-1:0] OE_SERIAL = 4'b1011;
   localparam logic [NPINS-1:0] OE_PAR    = 4'b1111;
endpackage

// File: rtl/sbp_rate.sv
module sbp_rate #(
   parameter int unsigned DIV_FAST = 2,
   parameter int unsigned DIV_SLOW = 256,
   localparam int unsigned CW = $clog2(DIV_SLOW)
) (
   input  logic          rate_sel,
   output logic [CW-1:0] half_m1
);
   localparam int unsigned FAST_M1 = DIV_FAST / 2 - 1;
   localparam int unsigned SLOW_M1 = DIV_SLOW / 2 - 1;

   initial begin
      assert (DIV_FAST >= 2 && DIV_FAST % 2 == 0) else $error("DIV_FAST must be even and >= 2");
      assert (DIV_SLOW >= DIV_FAST && DIV_SLOW % 2 == 0) else $error("DIV_SLOW must be even and >= DIV_FAST");
   end

   assign half_m1 = rate_sel ? CW'(SLOW_M1) : CW'(FAST_M1);
endmodule

// File: rtl/sbp_engine.sv
module sbp_engine #(
   parameter bit          IS_RX  = 1'b0,
   parameter int unsigned BITS   = 8,
   parameter int unsigned CW     = 8,
   localparam int unsigned EDGES = 2 * BITS,
   localparam int unsigned EW    = $clog2(EDGES) + 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [BITS-1:0] load_data,
   input  logic            din,
   input  logic            clr_busy,
   input  logic [CW-1:0]   half_m1,
   output logic            sclk,
   output logic            line,
   output logic [BITS-1:0] data,
   output logic            busy,
   output logic            evt
);
   initial assert (BITS >= 2) else $error("BITS must be >= 2");

   logic          act;
   logic [CW-1:0] hc;
   logic [EW-1:0] ec;
   logic          toggle;
   logic          fall_now, rise_now;
   logic [BITS-1:0] sh;

   assign toggle   = act && !start && (hc >= half_m1);
   assign fall_now = toggle && sclk;
   assign rise_now = toggle && !sclk;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act  <= 1'b0;
         busy <= 1'b0;
         evt  <= 1'b0;
         hc   <= '0;
         ec   <= '0;
         sclk <= 1'b1;
      end else begin
         evt <= 1'b0;
         if (clr_busy) busy <= 1'b0;
         if (start) begin
            act  <= 1'b1;
            busy <= 1'b1;
            hc   <= '0;
            ec   <= '0;
            sclk <= 1'b1;
         end else if (act) begin
            if (toggle) begin
               hc   <= '0;
               sclk <= ~sclk;
               ec   <= ec + 1'b1;
               if (rise_now && ec == EW'(EDGES - 1)) begin
                  act  <= 1'b0;
                  busy <= 1'b0;
                  evt  <= 1'b1;
               end
            end else begin
               hc <= hc + 1'b1;
            end
         end
      end
   end

   generate
      if (IS_RX) begin : g_rx
         // capture on rising edge, LSB first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        sh <= '0;
            else if (start)    sh <= load_data;
            else if (rise_now) sh <= {din, sh[BITS-1:1]};
         end
         assign line = 1'b1;
      end else begin : g_tx
         logic dq;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sh <= '0;
               dq <= 1'b1;
            end else if (start) begin
               sh <= load_data;
            end else if (fall_now) begin
               dq <= sh[0];
               sh <= {din, sh[BITS-1:1]};
            end
         end
         assign line = dq;

         p_data_steady_on_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(sclk) |-> $stable(line))
            else $error("transmit data moved on a rising clock edge");
      end
   endgenerate

   assign data = sh;

   p_idle_clock_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !busy && !act |-> sclk)
      else $error("shift clock low while idle");
   p_evt_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      evt |=> !evt)
      else $error("completion event longer than one cycle");
   p_evt_not_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      evt |-> !busy)
      else $error("busy still set at completion");
endmodule

// File: rtl/serial_byte_port.sv
module serial_byte_port
   import sbp_pkg::*;
#(
   parameter int unsigned DIV_FAST = 2,
   parameter int unsigned DIV_SLOW = 256,
   localparam int unsigned CW = $clog2(DIV_SLOW)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ser_mode,
   input  logic             rate_sel,
   input  logic             par_wr,
   input  logic [NIB_W-1:0] par_wdata,
   input  logic             tx_cmd,
   input  logic [NIB_W-1:0] tx_lo,
   input  logic [NIB_W-1:0] tx_hi,
   input  logic             rx_cmd,
   input  logic             stat_clr,
   input  logic             sdin,
   output logic [NIB_W-1:0] rx_lo,
   output logic [NIB_W-1:0] rx_hi,
   output logic [3:0]       stat,
   output logic             tx_evt,
   output logic             rx_evt,
   output logic [NPINS-1:0] pins_o,
   output logic [NPINS-1:0] pins_oe
);
   initial assert (2 * NIB_W == BYTE_W) else $error("byte must be two nibbles");

   logic [CW-1:0]     half_m1;
   logic              tx_sclk, tx_line, tx_busy;
   logic              rx_sclk, rx_line, rx_busy;
   logic [BYTE_W-1:0] tx_data, rx_data;
   logic [BYTE_W-1:0] rx_ret;
   logic [NIB_W-1:0]  par_q;

   sbp_rate #(.DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW)) u_rate (
      .rate_sel (rate_sel),
      .half_m1  (half_m1)
   );

   sbp_engine #(.IS_RX(1'b0), .BITS(BYTE_W), .CW(CW)) u_tx (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (tx_cmd),
      .load_data ({tx_hi, tx_lo}),
      .din       (1'b0),
      .clr_busy  (stat_clr),
      .half_m1   (half_m1),
      .sclk      (tx_sclk),
      .line      (tx_line),
      .data      (tx_data),
      .busy      (tx_busy),
      .evt       (tx_evt)
   );

   sbp_engine #(.IS_RX(1'b1), .BITS(BYTE_W), .CW(CW)) u_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (rx_cmd),
      .load_data ('0),
      .din       (sdin),
      .clr_busy  (stat_clr),
      .half_m1   (half_m1),
      .sclk      (rx_sclk),
      .line      (rx_line),
      .data      (rx_data),
      .busy      (rx_busy),
      .evt       (rx_evt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_ret <= '0;
         par_q  <= '0;
      end else begin
         if (rx_cmd) rx_ret <= rx_data;
         if (par_wr) par_q  <= par_wdata;
      end
   end

   assign rx_lo = rx_ret[NIB_W-1:0];
   assign rx_hi = rx_ret[BYTE_W-1:NIB_W];
   assign stat  = {tx_busy, 1'b0, rx_busy, 1'b0};

   logic [NPINS-1:0] ser_pins;
   always_comb begin
      ser_pins          = '0;
      ser_pins[PIN_TXD] = tx_line;
      ser_pins[PIN_TXC] = tx_sclk;
      ser_pins[PIN_RXD] = rx_line;
      ser_pins[PIN_RXC] = rx_sclk;
   end

   assign pins_o  = ser_mode ? ser_pins  : par_q;
   assign pins_oe = ser_mode ? OE_SERIAL : OE_PAR;

   p_din_not_driven_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ser_mode |-> !pins_oe[PIN_RXD] && pins_oe[PIN_TXC] && pins_oe[PIN_RXC])
      else $error("serial pin directions wrong");
   p_clear_drops_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      stat_clr && !tx_cmd && !rx_cmd |=> stat == 4'b0000)
      else $error("status not cleared");
   p_ret_only_on_cmd_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_cmd |=> $stable({rx_hi, rx_lo}))
      else $error("returned byte changed without a receive command");
endmodule

// File: tb/serial_byte_port_bench.sv
module serial_byte_port_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ser_mode = 1'b1, rate_sel = 1'b0, par_wr = 1'b0;
   logic [3:0] par_wdata = '0, tx_lo = '0, tx_hi = '0;
   logic       tx_cmd = 1'b0, rx_cmd = 1'b0, stat_clr = 1'b0, sdin = 1'b1;
   logic [3:0] rx_lo, rx_hi, stat, pins_o, pins_oe;
   logic       tx_evt, rx_evt;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   serial_byte_port u_serial_byte_port (
      .clk(clk), .rst_n(rst_n), .ser_mode(ser_mode), .rate_sel(rate_sel),
      .par_wr(par_wr), .par_wdata(par_wdata), .tx_cmd(tx_cmd), .tx_lo(tx_lo),
      .tx_hi(tx_hi), .rx_cmd(rx_cmd), .stat_clr(stat_clr), .sdin(sdin),
      .rx_lo(rx_lo), .rx_hi(rx_hi), .stat(stat), .tx_evt(tx_evt),
      .rx_evt(rx_evt), .pins_o(pins_o), .pins_oe(pins_oe)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic t_reset;
      check("R10 stat", stat, 0);
      check("R10 clocks high", {pins_o[3], pins_o[1]}, 2'b11);
      check("R10 tx data high", pins_o[0], 1);
      check("R10 returned byte", {rx_hi, rx_lo}, 0);
      ser_mode = 1'b0;
      #0.1;
      check("R10 parallel latch", pins_o, 0);
      ser_mode = 1'b1;
   endtask

   task automatic t_parallel;
      @(negedge clk);
      ser_mode = 1'b0; par_wr = 1'b1; par_wdata = 4'h9;
      @(negedge clk);
      par_wr = 1'b0;
      check("R1 pins", pins_o, 4'h9);
      check("R1 oe", pins_oe, 4'hF);
      par_wdata = 4'h6;
      @(negedge clk);
      check("R1 hold without strobe", pins_o, 4'h9);
      ser_mode = 1'b1;
      #0.1;
      check("R2 oe", pins_oe, 4'b1011);
      check("R2 idle pins", {pins_o[3], pins_o[1]}, 2'b11);
   endtask

   // mode: 0 plain, 1 clear status at cycle k, 2 restart with b2 at cycle k
   task automatic t_tx(input logic [7:0] b, input logic rate, input int mode,
                       input int k, input logic [7:0] b2);
      logic [7:0] got = '0;
      int nb = 0, busy_n = 0, ev_n = 0, i = 0;
      logic prev = 1'b1;
      logic resync = 1'b0;
      logic [7:0] expv = (mode == 2) ? b2 : b;
      @(negedge clk);
      rate_sel = rate; tx_lo = b[3:0]; tx_hi = b[7:4]; tx_cmd = 1'b1;
      while (ev_n == 0 && i < 5000) begin
         @(negedge clk);
         i++;
         tx_cmd = 1'b0;
         if (stat_clr) begin
            stat_clr = 1'b0;
         end
         if (mode == 1 && i == k + 1)
            check("R8 busy cleared mid-transfer", stat, 0);
         if (resync) begin
            resync = 1'b0;
         end else if (pins_o[1] && !prev) begin
            if (nb < 8) got[nb] = pins_o[0];
            nb++;
         end
         prev = pins_o[1];
         if (stat[3]) busy_n++;
         if (tx_evt) begin
            ev_n++;
            check("R5 busy clear at event", stat[3], 0);
         end
         if (mode == 1 && i == k) stat_clr = 1'b1;
         if (mode == 2 && i == k) begin
            tx_lo = b2[3:0]; tx_hi = b2[7:4]; tx_cmd = 1'b1;
            got = '0; nb = 0; resync = 1'b1;
         end
      end
      @(negedge clk);
      if (tx_evt) ev_n++;
      check((mode == 2) ? "R9 frame after restart" : "R4 frame", got, expv);
      check("R4 clock count", nb, 8);
      check((mode == 2) ? "R9 single event" : "R5 single event", ev_n, 1);
      if (mode == 0) check("R3 tx busy length", busy_n, rate ? 2048 : 16);
      check("R4 idle high after", pins_o[1], 1);
   endtask

   task automatic t_rx(input logic [7:0] b, input logic rate, input logic [7:0] exp_ret);
      int idx = 0, busy_n = 0, ev_n = 0, i = 0, nclk = 0;
      logic prev = 1'b1;
      @(negedge clk);
      rate_sel = rate; rx_cmd = 1'b1;
      @(negedge clk);
      rx_cmd = 1'b0;
      check("R6 returned previous byte", {rx_hi, rx_lo}, exp_ret);
      if (stat[1]) busy_n++;
      while (ev_n == 0 && i < 5000) begin
         i++;
         if (!pins_o[3] && prev) begin
            sdin = b[idx]; idx++;
         end
         if (pins_o[3] && !prev) nclk++;
         prev = pins_o[3];
         @(negedge clk);
         if (stat[1]) busy_n++;
         if (rx_evt) begin
            ev_n++;
            check("R7 busy clear at event", stat, 0);
            if (pins_o[3] && !prev) nclk++;
         end
      end
      @(negedge clk);
      if (rx_evt) ev_n++;
      check("R7 single event", ev_n, 1);
      check("R6 clock count", nclk, 8);
      check("R3 rx busy length", busy_n, rate ? 2048 : 16);
      sdin = 1'b1;
   endtask

   initial begin
      #2000000;
      errors++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_parallel();
      t_tx(8'hA6, 1'b0, 0, 0, 8'h00);
      t_tx(8'h3D, 1'b1, 0, 0, 8'h00);
      t_tx(8'h81, 1'b0, 1, 5, 8'h00);
      t_tx(8'hF0, 1'b0, 2, 6, 8'h5B);
      t_rx(8'hA5, 1'b0, 8'h00);
      t_rx(8'h3C, 1'b1, 8'hA5);
      t_rx(8'h01, 1'b0, 8'h3C);
      t_rx(8'h00, 1'b0, 8'h01);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule